// File: doc/BRIEF.md
# Two-Wire Target Port for a Clock/Calendar Register Space

This block is a target on a standard-mode two-wire serial bus, giving a bus controller byte access to a 64-entry register space. The first eight entries hold timekeeping and control bytes. The remaining 56 entries are general-purpose RAM. The block does not run the timekeeping. It stores and serves the bytes, and nothing on the register side sits outside it.

The bus lines are sampled with a fast system clock. SCL, SDA and the power-fail input all pass through the same two-flop synchroniser, so all three stay aligned to each other. The block pulls SDA low through an open-drain enable and never drives it high.

A write transaction sets a register pointer, then stores bytes at the pointer and advances it. A read transaction returns bytes starting at the pointer and advances it after each byte. A power-fail input ends any access at once, clears the pointer and makes the bus invisible to the block. The block has no valid/ready stream of its own: the serial bus is its only data path, and it applies no back-pressure (it never holds SCL low).

Top module: `clkcal_i2c_target`

## Requirements
- R1: After reset, `sda_pull_o` is 0, every register byte reads 00h, and the pointer is 00h, so a read with no pointer write returns the byte at 00h.
- R2: The block acknowledges an address byte only when its upper seven bits equal 7'b1101000. Otherwise it does not acknowledge, ignores every bit until the next START, and writes nothing.
- R3: In a write (bit 0 of the address byte = 0), the first data byte loads the pointer from its low six bits. Each later byte is stored at the pointer, the pointer then increments, and every such byte is acknowledged.
- R4: In a read (bit 0 = 1), bytes are sent MSB first, starting at the current pointer. The pointer advances after each byte. If no pointer was written, the read continues from the last pointer value.
- R5: The pointer wraps from 3Fh to 00h, for both writes and reads.
- R6: When the controller answers a read byte with NACK (SDA high on the ninth clock), the block releases SDA and sends no further bits before the next START.
- R7: A repeated START at any point restarts address reception and leaves the pointer unchanged.
- R8: While power-fail is high, `sda_pull_o` is 0, the pointer is forced to 00h, and no bus activity is decoded or written. If power-fail rises in the same cycle as the falling SCL edge that would store a byte, the store is suppressed.
- R9: `sda_pull_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired-AND value) |
| pwr_fail_i | input | 1 | High when supply is out of tolerance; aborts and blocks access |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |

## Verification
Power-fail abort and the store of a received data byte can land in the same system cycle. Both come from the falling SCL edge that ends the eighth bit, and power-fail passes through the same synchroniser as SCL. The bench raises power-fail in the same time step as that SCL fall, so the abort and the store meet at the engine in one cycle. It then checks that the target register still holds its old value, that no acknowledge was driven, and that a later read without a pointer write starts at 00h.

// File: rtl/cct_pkg.sv
package cct_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_TACK,
    ST_SKIP
  } eng_state_t;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);
endpackage

// File: rtl/cct_sync.sv
module cct_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cct_regfile.sv
module cct_regfile #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       ptr_load,
  input  logic       ptr_inc,
  input  logic       ptr_clr,
  input  logic [7:0] wdata,
  output logic [7:0] rd_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] PTR_TOP = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] ptr;
  logic [7:0]        mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ptr_clr) begin
      ptr <= '0;
    end else if (ptr_load) begin
      ptr <= wdata[ADDR_W-1:0];
    end else if (wr_en || ptr_inc) begin
      ptr <= ptr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[ptr] <= wdata;
    end
  end

  assign rd_data = mem[ptr];

  // R5
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_clr && !ptr_load && (wr_en || ptr_inc) && ptr == PTR_TOP) |=> ptr == '0);

  // R8
  ptr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> ptr == '0);

  // R8
  no_store_on_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !ptr_clr);
endmodule

// File: rtl/cct_engine.sv
module cct_engine
  import cct_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       pf_s,
  input  logic [7:0] rd_data,
  output logic       wr_en,
  output logic       ptr_load,
  output logic       ptr_inc,
  output logic       ptr_clr,
  output logic [7:0] wdata,
  output logic       sda_pull
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  eng_state_t        state;
  logic              scl_p, sda_p;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg, txsh;
  logic              byte_full, first_byte, rw_bit, m_ack, drv_ack, drv_tx;
  logic              start_det, stop_det, scl_rise, scl_fall, ev_ok;
  logic              rx_commit, tx_load;

  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign ev_ok     = ~pf_s & ~start_det & ~stop_det;

  assign rx_commit = ev_ok & scl_fall & byte_full & (state == ST_RX);
  assign tx_load   = ev_ok & scl_fall &
                     (((state == ST_AACK) & rw_bit) | ((state == ST_TACK) & m_ack));

  assign wr_en    = rx_commit & ~first_byte;
  assign ptr_load = rx_commit & first_byte;
  assign ptr_inc  = tx_load;
  assign ptr_clr  = pf_s;
  assign wdata    = shreg;
  assign sda_pull = drv_ack | (drv_tx & ~txsh[BYTE_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      txsh       <= '1;
      byte_full  <= 1'b0;
      first_byte <= 1'b0;
      rw_bit     <= 1'b0;
      m_ack      <= 1'b0;
      drv_ack    <= 1'b0;
      drv_tx     <= 1'b0;
    end else if (pf_s) begin
      state     <= ST_IDLE;
      byte_full <= 1'b0;
      drv_ack   <= 1'b0;
      drv_tx    <= 1'b0;
    end else if (start_det) begin
      state      <= ST_ADDR;
      bitcnt     <= '0;
      byte_full  <= 1'b0;
      first_byte <= 1'b1;
      drv_ack    <= 1'b0;
      drv_tx     <= 1'b0;
    end else if (stop_det) begin
      state     <= ST_IDLE;
      byte_full <= 1'b0;
      drv_ack   <= 1'b0;
      drv_tx    <= 1'b0;
    end else begin
      if (scl_rise && (state == ST_ADDR || state == ST_RX)) begin
        shreg  <= {shreg[BYTE_W-2:0], sda_s};
        bitcnt <= bitcnt + CNT_W'(1);
        if (bitcnt == LAST_BIT) byte_full <= 1'b1;
      end
      if (scl_rise && state == ST_TACK) m_ack <= ~sda_s;
      if (scl_fall) begin
        case (state)
          ST_ADDR: if (byte_full) begin
            byte_full <= 1'b0;
            if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
              state   <= ST_AACK;
              drv_ack <= 1'b1;
              rw_bit  <= shreg[0];
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_AACK: begin
            drv_ack <= 1'b0;
            bitcnt  <= '0;
            if (rw_bit) begin
              state  <= ST_TX;
              txsh   <= rd_data;
              drv_tx <= 1'b1;
            end else begin
              state <= ST_RX;
            end
          end
          ST_RX: if (byte_full) begin
            byte_full  <= 1'b0;
            first_byte <= 1'b0;
            drv_ack    <= 1'b1;
            state      <= ST_RACK;
          end
          ST_RACK: begin
            drv_ack <= 1'b0;
            bitcnt  <= '0;
            state   <= ST_RX;
          end
          ST_TX: begin
            if (bitcnt == LAST_BIT) begin
              drv_tx <= 1'b0;
              bitcnt <= '0;
              state  <= ST_TACK;
            end else begin
              bitcnt <= bitcnt + CNT_W'(1);
              txsh   <= {txsh[BYTE_W-2:0], 1'b1};
            end
          end
          ST_TACK: begin
            if (m_ack) begin
              txsh   <= rd_data;
              drv_tx <= 1'b1;
              bitcnt <= '0;
              state  <= ST_TX;
            end else begin
              state <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8
  pf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_s |=> !sda_pull);

  // R9
  pull_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_p && !pf_s) |-> sda_pull == $past(sda_pull));

  // R2
  addr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AACK && $past(state) == ST_ADDR) |-> $past(shreg[BYTE_W-1:1]) == DEV_ADDR);

  // R6
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !sda_pull);
endmodule

// File: rtl/clkcal_i2c_target.sv
module clkcal_i2c_target #(
  parameter logic [6:0]  DEV_ADDR    = 7'b1101000,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic pwr_fail_i,
  output logic sda_pull_o
);
  logic [2:0] sync_q;
  logic       wr_en, ptr_load, ptr_inc, ptr_clr;
  logic [7:0] wdata, rd_data;

  cct_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b111)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({pwr_fail_i, sda_i, scl_i}),
    .q     (sync_q)
  );

  cct_engine #(
    .DEV_ADDR (DEV_ADDR)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (sync_q[0]),
    .sda_s    (sync_q[1]),
    .pf_s     (sync_q[2]),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .ptr_load (ptr_load),
    .ptr_inc  (ptr_inc),
    .ptr_clr  (ptr_clr),
    .wdata    (wdata),
    .sda_pull (sda_pull_o)
  );

  cct_regfile #(
    .ADDR_W (ADDR_W)
  ) u_regfile (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .ptr_load (ptr_load),
    .ptr_inc  (ptr_inc),
    .ptr_clr  (ptr_clr),
    .wdata    (wdata),
    .rd_data  (rd_data)
  );
endmodule

// File: tb/test_clkcal_i2c_target.sv
module test_clkcal_i2c_target;
  localparam int H = 12;
  localparam logic [6:0] DEV = 7'b1101000;
  // {kind(1=read), pad, reg[5:0], data[7:0]}
  localparam logic [15:0] VEC [6] = '{
    {1'b0, 1'b0, 6'h00, 8'h5A},
    {1'b0, 1'b0, 6'h07, 8'h93},
    {1'b0, 1'b0, 6'h3F, 8'hC3},
    {1'b1, 1'b0, 6'h00, 8'h5A},
    {1'b1, 1'b0, 6'h07, 8'h93},
    {1'b1, 1'b0, 6'h3F, 8'hC3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, pwr_fail = 1'b0;
  logic sda_pull, sda_bus;
  int   checks = 0, failures = 0;
  logic [7:0] rbuf [4];
  logic ack_ok, rel_ok, mon_en = 1'b0, prev_pull = 1'b0;

  always #2 clk = ~clk;
  assign sda_bus = m_sda & ~sda_pull;

  clkcal_i2c_target i_clkcal_i2c_target (
    .clk (clk), .rst_n (rst_n), .scl_i (m_scl), .sda_i (sda_bus),
    .pwr_fail_i (pwr_fail), .sda_pull_o (sda_pull)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic bit_out(input logic b);
    m_sda = b; wt(H); m_scl = 1'b1; wt(H); m_scl = 1'b0; wt(2);
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H/2); b = sda_bus; wt(H/2); m_scl = 1'b0; wt(2);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(s); ack = ~s;
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(last);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b0; wt(H); m_scl = 1'b0; wt(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
  endtask

  task automatic do_write(input logic [7:0] ra, input int n,
                          input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    logic a;
    logic [7:0] bs [3];
    bs[0] = b0; bs[1] = b1; bs[2] = b2;
    bus_start();
    send_byte({DEV, 1'b0}, a); ack_ok = a;
    send_byte(ra, a); ack_ok &= a;
    for (int i = 0; i < n; i++) begin send_byte(bs[i], a); ack_ok &= a; end
    bus_stop();
  endtask

  task automatic read_tail(input int n);
    logic a;
    send_byte({DEV, 1'b1}, a); ack_ok &= a;
    for (int i = 0; i < n; i++) recv_byte(i == n - 1, rbuf[i]);
    wt(4); rel_ok = ~sda_pull;
    bus_stop();
  endtask

  task automatic do_read_at(input logic [7:0] ra, input int n);
    logic a;
    bus_start();
    send_byte({DEV, 1'b0}, a); ack_ok = a;
    send_byte(ra, a); ack_ok &= a;
    bus_start();
    read_tail(n);
  endtask

  task automatic do_read_cur(input int n);
    ack_ok = 1'b1;
    bus_start();
    read_tail(n);
  endtask

  // R9: pull-enable may change only while SCL is low
  always @(posedge clk) begin
    if (mon_en && sda_pull !== prev_pull) begin
      checks++;
      if (m_scl !== 1'b0) begin
        failures++;
        $display("FAIL R9 got=scl_high exp=scl_low");
      end
    end
    prev_pull = sda_pull;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic a;
    wt(5); rst_n = 1'b1; wt(5);
    chk("R1 idle pull", {7'd0, sda_pull}, 8'h00);
    mon_en = 1'b1;
    do_read_cur(1);
    chk("R1 reset pointer/data", rbuf[0], 8'h00);

    // table walk: R3 stores, R4 reads back
    for (int v = 0; v < 6; v++) begin
      if (VEC[v][15] == 1'b0) begin
        do_write({2'b00, VEC[v][13:8]}, 1, VEC[v][7:0], 8'h00, 8'h00);
        chk("R3 write acks", {7'd0, ack_ok}, 8'h01);
      end else begin
        do_read_at({2'b00, VEC[v][13:8]}, 1);
        chk("R4 read value", rbuf[0], VEC[v][7:0]);
        chk("R2 read acks", {7'd0, ack_ok}, 8'h01);
      end
    end

    // burst write and burst read
    do_write(8'h08, 3, 8'h11, 8'h22, 8'h33);
    do_read_at(8'h08, 3);
    chk("R3 burst b0", rbuf[0], 8'h11);
    chk("R4 burst b1", rbuf[1], 8'h22);
    chk("R4 burst b2", rbuf[2], 8'h33);
    chk("R6 release after NACK", {7'd0, rel_ok}, 8'h01);
    do_read_cur(1);
    chk("R4 last pointer kept", rbuf[0], 8'h00);

    // wrap at top of RAM
    do_write(8'h3F, 2, 8'hD1, 8'hE2, 8'h00);
    do_read_at(8'h3F, 2);
    chk("R5 wrap b0", rbuf[0], 8'hD1);
    chk("R5 wrap b1", rbuf[1], 8'hE2);

    // address mismatch
    bus_start();
    send_byte({7'h50, 1'b0}, a);
    chk("R2 mismatch no ack", {7'd0, a}, 8'h00);
    send_byte(8'h09, a);
    chk("R2 skipped byte no ack", {7'd0, a}, 8'h00);
    send_byte(8'hEE, a);
    bus_stop();
    do_read_at(8'h09, 1);
    chk("R2 no store", rbuf[0], 8'h22);

    // repeated start keeps pointer
    bus_start();
    send_byte({DEV, 1'b0}, a); send_byte(8'h08, a);
    bus_start();
    send_byte({DEV, 1'b0}, a);
    bus_start();
    read_tail(1);
    chk("R7 pointer kept", rbuf[0], 8'h11);

    // power fail resets the pointer
    do_write(8'h3F, 0, 8'h00, 8'h00, 8'h00);
    pwr_fail = 1'b1; wt(10); pwr_fail = 1'b0; wt(5);
    do_read_cur(1);
    chk("R8 pointer cleared", rbuf[0], 8'hE2);

    // power fail blocks bus input
    pwr_fail = 1'b1; wt(5);
    do_write(8'h05, 1, 8'h77, 8'h00, 8'h00);
    chk("R8 no ack while failed", {7'd0, ack_ok}, 8'h00);
    pwr_fail = 1'b0; wt(5);
    do_read_at(8'h05, 1);
    chk("R8 blocked write", rbuf[0], 8'h00);

    // power fail in same cycle as the store edge
    bus_start();
    send_byte({DEV, 1'b0}, a); send_byte(8'h06, a);
    for (int i = 7; i >= 1; i--) bit_out(8'h44 >> i);
    m_sda = 1'b0; wt(H); m_scl = 1'b1; wt(H);
    m_scl = 1'b0; pwr_fail = 1'b1;
    wt(6);
    chk("R8 no ack on abort", {7'd0, sda_pull}, 8'h00);
    wt(H); pwr_fail = 1'b0; wt(5);
    bus_stop();
    do_read_at(8'h06, 1);
    chk("R8 store suppressed", rbuf[0], 8'h00);
    do_read_at(8'h3F, 1);
    chk("R4 RAM intact", rbuf[0], 8'hD1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule